// File: doc/BRIEF.md
# Instruction Cache with Parity Refill Recovery

This block is a direct-mapped instruction cache whose data array keeps one even-parity bit beside every 64-bit doubleword. A fetch that finds its line absent, or finds the addressed doubleword with a parity mismatch, starts a line refill from the next cache level. The refill reads all doublewords of the line in ascending order over a valid/ready request channel. The next level answers each doubleword either as clean data or as data marked uncorrectable, together with an 8-bit mark identifier.

Clean doublewords are written back with correct parity, so a parity fault is repaired without any report to software. Marked doublewords are written with inverted parity, so they stay poisoned in the array. A fetch that lands on one gets its response tagged as poisoned and carries the mark identifier. The pipeline carries that tag with the instruction. When a poisoned instruction completes, the block raises a one-cycle trap request and records the event in a fault status register. A poisoned instruction that is squashed before completion leaves no trace.

Top module: `icache_parity_refill`

## Requirements
- R1: A fetch to a resident line whose addressed doubleword has matching even parity (parity bit equal to the XOR of all 64 data bits) is answered with the stored data in the cycle after acceptance, with no request to the next level.
- R2: A fetch whose line is absent or holds another tag fills the whole line: one request per doubleword, from doubleword 0 up to the last one of the line, and the response comes after the last beat.
- R3: A fetch that hits a resident doubleword with a parity mismatch rereads the entire line from the next level in the same ascending order, instead of returning the stored data.
- R4: A doubleword returned without the uncorrectable mark is stored with correct parity and answered with resp_poison=0. Later fetches to it hit without any refill.
- R5: A doubleword returned with the uncorrectable mark is stored with inverted parity. A fetch that needs it is answered with resp_poison=1 and resp_emid equal to the mark identifier. resp_emid is 0 whenever resp_poison is 0.
- R6: fetch_ready is low from the cycle after a fetch is accepted until its response has been given. While lo_req_valid is high and lo_req_ready is low, the request and its address hold steady.
- R7: A parity fault that the refill repairs changes neither trap_iae nor the fault status register.
- R8: A retiring instruction reported as squashed (ret_commit=0) raises no trap and leaves the fault status unchanged, even when poisoned.
- R9: A poisoned instruction that completes (ret_valid=1, ret_commit=1, ret_poison=1) drives trap_iae high for exactly the following cycle and sets fsr_valid=1, fsr_ue=1 and fsr_emid=ret_emid.
- R10: Once fsr_valid is set, later poisoned completions keep the first recorded identifier. A fsr_clr pulse clears all fields in the next cycle. A new event in the same cycle as fsr_clr wins and is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Fetch request valid |
| fetch_addr | input | 32 | Fetch byte address |
| fetch_ready | output | 1 | Fetch request accepted when high |
| resp_valid | output | 1 | Fetch response valid, one cycle |
| resp_data | output | 64 | Fetched doubleword |
| resp_poison | output | 1 | Response carries an uncorrectable mark |
| resp_emid | output | 8 | Mark identifier of a poisoned response |
| lo_req_valid | output | 1 | Refill request to the next level |
| lo_req_dwaddr | output | 29 | Doubleword address of the refill request |
| lo_req_ready | input | 1 | Next level delivers data this cycle |
| lo_data | input | 64 | Refill doubleword |
| lo_ue | input | 1 | Refill doubleword marked uncorrectable |
| lo_emid | input | 8 | Mark identifier of the refill doubleword |
| ret_valid | input | 1 | An instruction leaves the pipeline |
| ret_commit | input | 1 | 1: completed, 0: squashed |
| ret_poison | input | 1 | Instruction was fetched poisoned |
| ret_emid | input | 8 | Mark identifier carried with it |
| fsr_clr | input | 1 | Write-one-to-clear pulse for the fault status |
| trap_iae | output | 1 | Instruction access error trap request |
| fsr_valid | output | 1 | Fault status holds an event |
| fsr_ue | output | 1 | Recorded event was a marked uncorrectable error |
| fsr_emid | output | 8 | Recorded mark identifier |

## Verification
The hardest case to reach is a parity mismatch on a resident hit, because no port writes the array with bad parity directly. The stimulus first makes the next level mark one doubleword uncorrectable during a fill, which leaves it stored poisoned. It then withdraws the mark and fetches the same doubleword again, which forces the reread and the repair. Random traffic then enables a hashed mark pattern across a few tags, so miss fills, poisoned hits and repairs mix, while the next level stalls its handshake at random.

// File: rtl/icpr_pkg.sv
package icpr_pkg;
    localparam int ICPR_DW     = 64;
    localparam int ICPR_EMID_W = 8;
    localparam int ICPR_OFF_W  = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOK,
        ST_FILL,
        ST_RESP
    } icpr_state_e;

    typedef struct packed {
        logic [ICPR_DW-1:0]     data;
        logic                   ue;
        logic [ICPR_EMID_W-1:0] emid;
    } icpr_beat_t;

    function automatic logic even_par(input logic [ICPR_DW-1:0] d);
        return ^d;
    endfunction
endpackage

// File: rtl/icpr_data_array.sv
module icpr_data_array
    import icpr_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = 8
) (
    input  logic            clk,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [ICPR_DW:0] wr_word,
    input  logic            rd_en,
    input  logic [AW-1:0]   rd_addr,
    output logic [ICPR_DW:0] rd_word
);
    logic [ICPR_DW:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_word;
        if (rd_en) rd_word <= mem[rd_addr];
    end
endmodule

// File: rtl/icpr_tag_array.sv
module icpr_tag_array #(
    parameter int LINES = 64,
    parameter int IDX_W = 6,
    parameter int TAG_W = 21
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_vld,
    output logic [TAG_W-1:0] rd_tag
);
    logic [LINES-1:0] vld_q;
    logic [TAG_W-1:0] tag_q [LINES];

    always_ff @(posedge clk) begin
        if (rst) vld_q <= '0;
        else if (wr_en) vld_q[wr_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en) tag_q[wr_idx] <= wr_tag;
    end

    assign rd_vld = vld_q[rd_idx];
    assign rd_tag = tag_q[rd_idx];
endmodule

// File: rtl/icpr_fault_status.sv
module icpr_fault_status #(
    parameter int EMID_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ret_valid,
    input  logic              ret_commit,
    input  logic              ret_poison,
    input  logic [EMID_W-1:0] ret_emid,
    input  logic              clr,
    output logic              trap,
    output logic              st_valid,
    output logic              st_ue,
    output logic [EMID_W-1:0] st_emid
);
    logic hit_event;
    assign hit_event = ret_valid && ret_commit && ret_poison;

    always_ff @(posedge clk) begin
        if (rst) begin
            trap     <= 1'b0;
            st_valid <= 1'b0;
            st_ue    <= 1'b0;
            st_emid  <= '0;
        end else begin
            trap <= hit_event;
            if (hit_event) begin
                st_valid <= 1'b1;
                st_ue    <= 1'b1;
                if (!st_valid || clr) st_emid <= ret_emid;
            end else if (clr) begin
                st_valid <= 1'b0;
                st_ue    <= 1'b0;
                st_emid  <= '0;
            end
        end
    end
endmodule

// File: rtl/icache_parity_refill.sv
module icache_parity_refill
    import icpr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LINES  = 64,
    parameter int WORDS  = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     fetch_valid,
    input  logic [ADDR_W-1:0]        fetch_addr,
    output logic                     fetch_ready,
    output logic                     resp_valid,
    output logic [ICPR_DW-1:0]       resp_data,
    output logic                     resp_poison,
    output logic [ICPR_EMID_W-1:0]   resp_emid,
    output logic                     lo_req_valid,
    output logic [ADDR_W-ICPR_OFF_W-1:0] lo_req_dwaddr,
    input  logic                     lo_req_ready,
    input  logic [ICPR_DW-1:0]       lo_data,
    input  logic                     lo_ue,
    input  logic [ICPR_EMID_W-1:0]   lo_emid,
    input  logic                     ret_valid,
    input  logic                     ret_commit,
    input  logic                     ret_poison,
    input  logic [ICPR_EMID_W-1:0]   ret_emid,
    input  logic                     fsr_clr,
    output logic                     trap_iae,
    output logic                     fsr_valid,
    output logic                     fsr_ue,
    output logic [ICPR_EMID_W-1:0]   fsr_emid
);
    localparam int WSEL_W = $clog2(WORDS);
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - IDX_W - WSEL_W - ICPR_OFF_W;
    localparam int MA_W   = IDX_W + WSEL_W;
    localparam int DEPTH  = LINES * WORDS;
    localparam logic [WSEL_W-1:0] LAST_W = WSEL_W'(WORDS - 1);

    icpr_state_e        st_q;
    logic [ADDR_W-1:0]  req_q;
    logic [WSEL_W-1:0]  cnt_q;
    icpr_beat_t         beat_q;

    logic [TAG_W-1:0]   req_tag;
    logic [IDX_W-1:0]   req_idx;
    logic [WSEL_W-1:0]  req_wsel;
    logic [ICPR_DW:0]   arr_word;
    logic               tag_vld;
    logic [TAG_W-1:0]   tag_rd;
    logic               accept, beat, last_beat, line_hit, par_ok, clean_hit;

    assign req_tag  = req_q[ADDR_W-1 -: TAG_W];
    assign req_idx  = req_q[ICPR_OFF_W+WSEL_W +: IDX_W];
    assign req_wsel = req_q[ICPR_OFF_W +: WSEL_W];

    assign fetch_ready  = (st_q == ST_IDLE);
    assign accept       = fetch_valid && fetch_ready;
    assign lo_req_valid = (st_q == ST_FILL);
    assign lo_req_dwaddr = {req_tag, req_idx, cnt_q};
    assign beat         = lo_req_valid && lo_req_ready;
    assign last_beat    = beat && (cnt_q == LAST_W);

    icpr_data_array #(.DEPTH(DEPTH), .AW(MA_W)) u_data (
        .clk     (clk),
        .wr_en   (beat),
        .wr_addr ({req_idx, cnt_q}),
        .wr_word ({even_par(lo_data) ^ lo_ue, lo_data}),
        .rd_en   (accept),
        .rd_addr (fetch_addr[ICPR_OFF_W +: MA_W]),
        .rd_word (arr_word)
    );

    icpr_tag_array #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tag (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (last_beat),
        .wr_idx (req_idx),
        .wr_tag (req_tag),
        .rd_idx (req_idx),
        .rd_vld (tag_vld),
        .rd_tag (tag_rd)
    );

    icpr_fault_status #(.EMID_W(ICPR_EMID_W)) u_fsr (
        .clk        (clk),
        .rst        (rst),
        .ret_valid  (ret_valid),
        .ret_commit (ret_commit),
        .ret_poison (ret_poison),
        .ret_emid   (ret_emid),
        .clr        (fsr_clr),
        .trap       (trap_iae),
        .st_valid   (fsr_valid),
        .st_ue      (fsr_ue),
        .st_emid    (fsr_emid)
    );

    assign line_hit  = tag_vld && (tag_rd == req_tag);
    assign par_ok    = (even_par(arr_word[ICPR_DW-1:0]) == arr_word[ICPR_DW]);
    assign clean_hit = (st_q == ST_LOOK) && line_hit && par_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            req_q  <= '0;
            cnt_q  <= '0;
            beat_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (accept) begin
                    req_q <= fetch_addr;
                    st_q  <= ST_LOOK;
                end
                ST_LOOK: begin
                    cnt_q <= '0;
                    st_q  <= clean_hit ? ST_IDLE : ST_FILL;
                end
                ST_FILL: if (beat) begin
                    if (cnt_q == req_wsel) beat_q <= '{data: lo_data, ue: lo_ue, emid: lo_emid};
                    cnt_q <= cnt_q + 1'b1;
                    if (last_beat) st_q <= ST_RESP;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        resp_valid  = clean_hit || (st_q == ST_RESP);
        resp_data   = (st_q == ST_RESP) ? beat_q.data : arr_word[ICPR_DW-1:0];
        resp_poison = (st_q == ST_RESP) && beat_q.ue;
        resp_emid   = resp_poison ? beat_q.emid : '0;
    end
endmodule

// File: rtl/icpr_checker.sv
module icpr_checker #(
    parameter int ADDR_W = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                fetch_valid,
    input logic                fetch_ready,
    input logic                resp_valid,
    input logic                resp_poison,
    input logic [7:0]          resp_emid,
    input logic                lo_req_valid,
    input logic [ADDR_W-4:0]   lo_req_dwaddr,
    input logic                lo_req_ready,
    input logic                ret_valid,
    input logic                ret_commit,
    input logic                ret_poison,
    input logic                fsr_clr,
    input logic                trap_iae,
    input logic                fsr_valid,
    input logic [7:0]          fsr_emid
);
    a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        fetch_valid && fetch_ready |=> !fetch_ready);

    a_r6_req_hold: assert property (@(posedge clk) disable iff (rst)
        lo_req_valid && !lo_req_ready |=> lo_req_valid && $stable(lo_req_dwaddr));

    a_r6_no_fetch_during_fill: assert property (@(posedge clk) disable iff (rst)
        lo_req_valid |-> !fetch_ready && !resp_valid);

    a_r5_poison_needs_resp: assert property (@(posedge clk) disable iff (rst)
        resp_poison |-> resp_valid);

    a_r5_emid_zero_clean: assert property (@(posedge clk) disable iff (rst)
        !resp_poison |-> resp_emid == 8'h00);

    a_r8_squash_no_trap: assert property (@(posedge clk) disable iff (rst)
        ret_valid && !ret_commit |=> !trap_iae);

    a_r9_trap_cause: assert property (@(posedge clk) disable iff (rst)
        trap_iae |-> $past(ret_valid && ret_commit && ret_poison));

    a_r9_trap_sets_fsr: assert property (@(posedge clk) disable iff (rst)
        trap_iae |-> fsr_valid);

    a_r10_sticky_id: assert property (@(posedge clk) disable iff (rst)
        fsr_valid && !fsr_clr |=> fsr_valid && $stable(fsr_emid));
endmodule

bind icache_parity_refill icpr_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .fetch_valid   (fetch_valid),
    .fetch_ready   (fetch_ready),
    .resp_valid    (resp_valid),
    .resp_poison   (resp_poison),
    .resp_emid     (resp_emid),
    .lo_req_valid  (lo_req_valid),
    .lo_req_dwaddr (lo_req_dwaddr),
    .lo_req_ready  (lo_req_ready),
    .ret_valid     (ret_valid),
    .ret_commit    (ret_commit),
    .ret_poison    (ret_poison),
    .fsr_clr       (fsr_clr),
    .trap_iae      (trap_iae),
    .fsr_valid     (fsr_valid),
    .fsr_emid      (fsr_emid)
);

// File: tb/icache_parity_refill_tb.sv
module icache_parity_refill_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        fetch_ready, resp_valid, resp_poison;
    logic [63:0] resp_data;
    logic [7:0]  resp_emid;
    logic        lo_req_valid;
    logic [28:0] lo_req_dwaddr;
    logic        lo_req_ready = 1'b0;
    logic [63:0] lo_data = '0;
    logic        lo_ue = 1'b0;
    logic [7:0]  lo_emid = '0;
    logic        ret_valid = 1'b0, ret_commit = 1'b0, ret_poison = 1'b0;
    logic [7:0]  ret_emid = '0;
    logic        fsr_clr = 1'b0;
    logic        trap_iae, fsr_valid, fsr_ue;
    logic [7:0]  fsr_emid;

    always #2 clk = ~clk;

    icache_parity_refill u_dut (
        .clk(clk), .rst(rst),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_ready(fetch_ready),
        .resp_valid(resp_valid), .resp_data(resp_data), .resp_poison(resp_poison),
        .resp_emid(resp_emid),
        .lo_req_valid(lo_req_valid), .lo_req_dwaddr(lo_req_dwaddr),
        .lo_req_ready(lo_req_ready), .lo_data(lo_data), .lo_ue(lo_ue), .lo_emid(lo_emid),
        .ret_valid(ret_valid), .ret_commit(ret_commit), .ret_poison(ret_poison),
        .ret_emid(ret_emid), .fsr_clr(fsr_clr),
        .trap_iae(trap_iae), .fsr_valid(fsr_valid), .fsr_ue(fsr_ue), .fsr_emid(fsr_emid)
    );

    int n_chk = 0, n_fail = 0, n_fill = 0, cyc = 0;
    logic [28:0] fill_log [8];
    bit          ue_force_en = 0, ue_rand_en = 0;
    logic [28:0] ue_force_dw = '0;
    int unsigned gen = 0;

    bit          mdl_vld [64];
    logic [20:0] mdl_tag [64];
    logic [63:0] mdl_data [256];
    bit          mdl_psn [256];

    function automatic logic [63:0] lo_data_fn(logic [28:0] dw);
        return {32'(dw) ^ 32'hA5A5_0000 ^ gen, ~32'(dw) ^ (gen * 32'h9E37)};
    endfunction
    function automatic bit lo_ue_fn(logic [28:0] dw);
        return (ue_force_en && dw == ue_force_dw) ||
               (ue_rand_en && ((32'(dw) * 13 + gen) % 7 == 0));
    endfunction
    function automatic logic [7:0] lo_emid_fn(logic [28:0] dw);
        return dw[7:0] ^ gen[7:0] ^ 8'h3C;
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // next-level model: random stalls, data driven from the stable request address
    always @(negedge clk) begin
        lo_req_ready = lo_req_valid && ($urandom % 4 != 0);
        lo_data = lo_data_fn(lo_req_dwaddr);
        lo_ue   = lo_ue_fn(lo_req_dwaddr);
        lo_emid = lo_emid_fn(lo_req_dwaddr);
        if (lo_req_ready) begin
            fill_log[n_fill % 8] = lo_req_dwaddr;
            n_fill++;
        end
    end

    task automatic fetch(logic [20:0] tag, logic [5:0] idx, logic [1:0] ws, string tagreq);
        int f0, nf, line;
        bit hit;
        logic [63:0] exp_d;
        bit exp_p;
        logic [7:0] exp_e;
        line = int'(idx) * 4;
        hit = mdl_vld[idx] && mdl_tag[idx] == tag && !mdl_psn[line + int'(ws)];
        if (!hit) begin
            for (int k = 0; k < 4; k++) begin
                mdl_data[line + k] = lo_data_fn({tag, idx, 2'(k)});
                mdl_psn[line + k]  = lo_ue_fn({tag, idx, 2'(k)});
            end
            mdl_vld[idx] = 1;
            mdl_tag[idx] = tag;
        end
        exp_d = mdl_data[line + int'(ws)];
        exp_p = mdl_psn[line + int'(ws)];
        exp_e = exp_p ? lo_emid_fn({tag, idx, ws}) : 8'h00;
        @(negedge clk);
        fetch_valid = 1'b1;
        fetch_addr  = {tag, idx, ws, 3'b000};
        while (!fetch_ready) @(negedge clk);
        f0 = n_fill;
        @(negedge clk);
        fetch_valid = 1'b0;
        chk(!fetch_ready, {tagreq, " R6 busy after accept"}, 64'(fetch_ready), 0);
        while (!resp_valid) @(negedge clk);
        nf = n_fill - f0;
        chk(resp_data == exp_d, {tagreq, " data"}, resp_data, exp_d);
        chk(resp_poison == exp_p, {tagreq, " R5 poison flag"}, 64'(resp_poison), 64'(exp_p));
        chk(resp_emid == exp_e, {tagreq, " R5 mark id"}, 64'(resp_emid), 64'(exp_e));
        chk(nf == (hit ? 0 : 4), {tagreq, " refill beat count"}, 64'(nf), hit ? 0 : 4);
        if (!hit && nf == 4)
            for (int k = 0; k < 4; k++)
                chk(fill_log[(f0 + k) % 8] == {tag, idx, 2'(k)}, {tagreq, " R2 ascending order"},
                    64'(fill_log[(f0 + k) % 8]), 64'({tag, idx, 2'(k)}));
    endtask

    task automatic retire(bit commit, bit psn, logic [7:0] id, bit clr);
        @(negedge clk);
        ret_valid = 1'b1; ret_commit = commit; ret_poison = psn; ret_emid = id; fsr_clr = clr;
        @(negedge clk);
        ret_valid = 1'b0; ret_commit = 1'b0; ret_poison = 1'b0; fsr_clr = 1'b0;
    endtask

    task automatic chk_fsr(bit t, bit v, logic [7:0] id, string req);
        chk(trap_iae == t, {req, " trap"}, 64'(trap_iae), 64'(t));
        chk(fsr_valid == v && fsr_ue == v, {req, " fsr valid/ue"}, 64'({fsr_valid, fsr_ue}), 64'({v, v}));
        chk(fsr_emid == id, {req, " fsr id"}, 64'(fsr_emid), 64'(id));
    endtask

    initial begin
        void'($urandom(32'h1C4E));
        for (int i = 0; i < 64; i++) mdl_vld[i] = 0;
        for (int i = 0; i < 256; i++) mdl_psn[i] = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(fetch_ready && !resp_valid && !lo_req_valid, "reset handshake state",
            64'({fetch_ready, resp_valid, lo_req_valid}), 64'(3'b100));
        chk_fsr(0, 0, 8'h00, "reset");

        fetch(21'h11, 6'd5, 2'd2, "R2 miss fill");
        fetch(21'h11, 6'd5, 2'd0, "R1 clean hit");
        fetch(21'h12, 6'd5, 2'd3, "R2 tag replace");

        ue_force_en = 1; ue_force_dw = {21'h07, 6'd9, 2'd1};
        fetch(21'h07, 6'd9, 2'd1, "R5 marked fill");
        fetch(21'h07, 6'd9, 2'd1, "R5 poisoned hit rereads");
        ue_force_en = 0;
        gen = 3;
        fetch(21'h07, 6'd9, 2'd1, "R3 parity reread");
        fetch(21'h07, 6'd9, 2'd1, "R4 repaired hit");
        fetch(21'h07, 6'd9, 2'd3, "R4 neighbour kept");
        chk_fsr(0, 0, 8'h00, "R7 silent repair");

        retire(0, 1, 8'h44, 0);
        chk_fsr(0, 0, 8'h00, "R8 squashed");
        retire(1, 0, 8'h00, 0);
        chk_fsr(0, 0, 8'h00, "R9 clean completion");
        retire(1, 1, 8'hA1, 0);
        chk_fsr(1, 1, 8'hA1, "R9 poisoned completion");
        @(negedge clk);
        chk(!trap_iae, "R9 one-cycle trap", 64'(trap_iae), 0);
        retire(1, 1, 8'hB2, 0);
        chk_fsr(1, 1, 8'hA1, "R10 first id kept");
        retire(0, 0, 8'h00, 1);
        chk_fsr(0, 0, 8'h00, "R10 clear");
        retire(1, 1, 8'hC3, 0);
        retire(1, 1, 8'hD4, 1);
        chk_fsr(1, 1, 8'hD4, "R10 set beats clear");

        ue_rand_en = 1;
        for (int i = 0; i < 400; i++) begin
            if ($urandom % 40 == 0) gen = gen + 1;
            fetch(21'($urandom % 4), 6'($urandom), 2'($urandom), "R1 R3 R4 random");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule